// File: doc/BRIEF.md
# Turbo Energy-Budget Frequency Governor

This block picks one operating-point index for a group of cores that share a clock. Index 0 is the fastest point. Larger indices are slower, down to the most energy-efficient point `PN_IDX`. `P1_IDX` is the guaranteed point. The indices below it are turbo bins, and only this block selects them. The operating system sees them as a single request, index 0, which means "turbo allowed".

The block acts only on cycles where `tick` is high. On each tick it updates a signed energy budget by adding the sustained power limit and subtracting the measured power. The result is clipped at zero and at a programmable ceiling. Under a turbo request, a non-empty budget lets the cores climb toward the highest bin that the current active-core count allows. Once the budget is empty and the measured power is over the limit, the governor walks back down to the guaranteed point. This makes the average power settle at the limit under a steady load.

Inactive cores are reported as power-gated. Fewer active cores unlock faster bins.

Top module: `turbo_governor`

## Requirements
- R1: After reset the operating point is `P1_IDX` (4 by default), the budget is 0 and no core is reported gated.
- R2: On each tick the budget becomes budget + `pwr_limit` − `pwr_meas`. A result below zero gives 0.
- R3: A budget result above `budget_max` gives `budget_max`. This also applies when `budget_max` was lowered below the stored budget.
- R4: On each tick `gated_out` takes the bitwise inverse of `core_active`. Bit i = 1 means core i is gated.
- R5: The highest bin allowed under a turbo request depends on the number k of active cores. It is 0 for k ≤ 1, and otherwise floor((k−1)·(`P1_IDX`−1)/(`NUM_CORES`−1)). With the defaults this gives k = 1→0, 2→1, 3→2, 4→3.
- R6: The operating point moves by at most one index per tick. Without a tick, the operating point, the budget and the gated mask all hold.
- R7: Under a turbo request (`os_req` = 0), the point steps toward the R5 top bin, unless R8 applies.
- R8: Under a turbo request with the budget at 0 and `pwr_meas` > `pwr_limit`, the point steps toward `P1_IDX` and never settles faster than it.
- R9: For a non-zero `os_req`, the target is `os_req`. Values 1 to `P1_IDX`−1 map to `P1_IDX`, and values above `PN_IDX` (10 by default) map to `PN_IDX`.
- R10: The bin decision on a tick uses the budget stored before that tick's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Control-tick strobe, one cycle wide |
| os_req | input | IDX_W | Requested operating point; 0 allows turbo |
| pwr_meas | input | PWR_W | Package power measured over the last tick |
| pwr_limit | input | PWR_W | Sustained power limit per tick |
| budget_max | input | BUD_W | Budget ceiling |
| core_active | input | NUM_CORES | Per-core activity mask |
| pstate_out | output | IDX_W | Current shared operating-point index |
| gated_out | output | NUM_CORES | Per-core power-gated flags |
| budget_out | output | BUD_W | Stored energy budget |

## Verification
Two events can land on the same tick: the budget being drained to zero, and the bin decision that depends on that budget. The bench reaches this by running at the top bin with a small stored budget and then applying power far above the limit. On that tick the budget must drop to zero while the operating point still holds. The step back toward the guaranteed point must come only on the following tick. A scoreboard model computes every expected value from the requirements, and the monitor compares each one cycle after the tick that produced it.

// File: rtl/governor_pkg.sv
// governor_pkg: shared types and the top-bin formula for the turbo governor.
// Assumes p1 >= 1 and n >= 1; the top bin of a full core group is p1 - 1.
package governor_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_FASTER = 2'd1,
        STEP_SLOWER = 2'd2
    } step_dir_e;

    // Highest turbo bin index allowed for k active cores out of n.
    function automatic int cap_bin_f(input int k, input int n, input int p1);
        if (k <= 1 || n <= 1) return 0;
        return ((k - 1) * (p1 - 1)) / (n - 1);
    endfunction

endpackage

// File: rtl/gov_bin_cap.sv
// gov_bin_cap: counts active cores and looks up the fastest turbo bin they may use.
// Assumes the table is fixed at elaboration; purely combinational.
module gov_bin_cap
    import governor_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 4,
    parameter int P1_IDX    = 4
) (
    input  logic [NUM_CORES-1:0] core_active,
    output logic [IDX_W-1:0]     cap_idx
);
    localparam int CNT_W = $clog2(NUM_CORES + 1);

    logic [CNT_W-1:0] act_cnt;
    logic [IDX_W-1:0] cap_tab [NUM_CORES+1];

    // one table entry per possible active-core count
    for (genvar k = 0; k <= NUM_CORES; k++) begin : g_tab
        assign cap_tab[k] = IDX_W'(cap_bin_f(k, NUM_CORES, P1_IDX));
    end

    // population count of the activity mask
    always_comb begin
        act_cnt = '0;
        for (int i = 0; i < NUM_CORES; i++) act_cnt = act_cnt + CNT_W'(core_active[i]);
    end

    // select the entry matching the count
    always_comb begin
        cap_idx = '0;
        for (int k = 0; k <= NUM_CORES; k++)
            if (act_cnt == CNT_W'(k)) cap_idx = cap_tab[k];
    end

endmodule

// File: rtl/gov_budget.sv
// gov_budget: energy-budget accumulator, updated once per control tick.
// Assumes PWR_W <= BUD_W; clipped to [0, budget_max] on every update.
module gov_budget #(
    parameter int PWR_W = 12,
    parameter int BUD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PWR_W-1:0] pwr_meas,
    input  logic [PWR_W-1:0] pwr_limit,
    input  logic [BUD_W-1:0] budget_max,
    output logic [BUD_W-1:0] budget_q,
    output logic             budget_empty
);
    localparam int SUM_W = BUD_W + 2;

    logic signed [SUM_W-1:0] sum_s;
    logic [BUD_W-1:0]        budget_d;

    // raw update: budget + limit - measured power
    always_comb begin
        sum_s = $signed({2'b00, budget_q})
              + $signed({{(SUM_W-PWR_W){1'b0}}, pwr_limit})
              - $signed({{(SUM_W-PWR_W){1'b0}}, pwr_meas});
    end

    // clip to zero and to the programmable ceiling
    always_comb begin
        if (sum_s < 0)                              budget_d = '0;
        else if (sum_s > $signed({2'b00, budget_max})) budget_d = budget_max;
        else                                        budget_d = sum_s[BUD_W-1:0];
    end

    // budget register, written only on ticks
    always_ff @(posedge clk) begin
        if (!rst_n)    budget_q <= '0;
        else if (tick) budget_q <= budget_d;
    end

    assign budget_empty = (budget_q == '0);

    AST_BUDGET_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> budget_q <= $past(budget_max)); // R3
    AST_BUDGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(budget_q)); // R6
    AST_BUDGET_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && budget_empty && pwr_meas >= pwr_limit) |=> budget_q == '0); // R2

endmodule

// File: rtl/gov_stepper.sv
// gov_stepper: picks the target operating point and moves one bin toward it per tick.
// Assumes cap_idx < P1_IDX <= PN_IDX; lower index means higher frequency.
module gov_stepper
    import governor_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int P1_IDX = 4,
    parameter int PN_IDX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [IDX_W-1:0] os_req,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             budget_empty,
    input  logic             over_limit,
    output logic [IDX_W-1:0] pstate_q
);
    localparam logic [IDX_W-1:0] P1_L = IDX_W'(P1_IDX);
    localparam logic [IDX_W-1:0] PN_L = IDX_W'(PN_IDX);

    logic [IDX_W-1:0] target;
    step_dir_e        dir;

    // target point: turbo request, budget-exhausted retreat, or clamped OS request
    always_comb begin
        if (os_req == '0)      target = (budget_empty && over_limit) ? P1_L : cap_idx;
        else if (os_req < P1_L) target = P1_L;
        else if (os_req > PN_L) target = PN_L;
        else                   target = os_req;
    end

    // direction of the single-bin move
    always_comb begin
        if (pstate_q > target)      dir = STEP_FASTER;
        else if (pstate_q < target) dir = STEP_SLOWER;
        else                        dir = STEP_HOLD;
    end

    // operating-point register
    always_ff @(posedge clk) begin
        if (!rst_n) pstate_q <= P1_L;
        else if (tick) begin
            case (dir)
                STEP_FASTER: pstate_q <= pstate_q - 1'b1;
                STEP_SLOWER: pstate_q <= pstate_q + 1'b1;
                default:     pstate_q <= pstate_q;
            endcase
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pstate_q == $past(pstate_q) || pstate_q == $past(pstate_q) + 1'b1
                  || pstate_q + 1'b1 == $past(pstate_q))); // R6
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pstate_q)); // R6
    AST_CAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && os_req == '0 && pstate_q >= cap_idx) |=> pstate_q >= $past(cap_idx)); // R7
    AST_EMPTY_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && os_req == '0 && budget_empty && over_limit && pstate_q < P1_L)
        |=> pstate_q == $past(pstate_q) + 1'b1); // R8
    AST_NO_TURBO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && os_req != '0 && pstate_q >= P1_L) |=> pstate_q >= P1_L); // R9

endmodule

// File: rtl/turbo_governor.sv
// turbo_governor: shared operating-point governor paid for by an energy budget.
// Assumes tick is a one-cycle strobe and power values share one unit per tick.
module turbo_governor #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 4,
    parameter int P1_IDX    = 4,
    parameter int PN_IDX    = 10,
    parameter int PWR_W     = 12,
    parameter int BUD_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [IDX_W-1:0]     os_req,
    input  logic [PWR_W-1:0]     pwr_meas,
    input  logic [PWR_W-1:0]     pwr_limit,
    input  logic [BUD_W-1:0]     budget_max,
    input  logic [NUM_CORES-1:0] core_active,
    output logic [IDX_W-1:0]     pstate_out,
    output logic [NUM_CORES-1:0] gated_out,
    output logic [BUD_W-1:0]     budget_out
);
    logic [IDX_W-1:0]     cap_idx;
    logic                 budget_empty;
    logic                 over_limit;
    logic [NUM_CORES-1:0] gated_q;

    assign over_limit = (pwr_meas > pwr_limit);

    gov_bin_cap #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .P1_IDX(P1_IDX)) u_cap (
        .core_active (core_active),
        .cap_idx     (cap_idx)
    );

    gov_budget #(.PWR_W(PWR_W), .BUD_W(BUD_W)) u_budget (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .pwr_meas     (pwr_meas),
        .pwr_limit    (pwr_limit),
        .budget_max   (budget_max),
        .budget_q     (budget_out),
        .budget_empty (budget_empty)
    );

    gov_stepper #(.IDX_W(IDX_W), .P1_IDX(P1_IDX), .PN_IDX(PN_IDX)) u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .os_req       (os_req),
        .cap_idx      (cap_idx),
        .budget_empty (budget_empty),
        .over_limit   (over_limit),
        .pstate_q     (pstate_out)
    );

    // gate flags for inactive cores, refreshed on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    gated_q <= '0;
        else if (tick) gated_q <= ~core_active;
    end

    assign gated_out = gated_q;

    AST_GATE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> gated_out == ~$past(core_active)); // R4
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(gated_out)); // R6

endmodule

// File: tb/turbo_governor_test.sv
module turbo_governor_test;
    localparam int P1 = 4;
    localparam int PN = 10;

    typedef struct {
        int         p;
        int         b;
        logic [3:0] g;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  os_req = '0;
    logic [11:0] pwr_meas = '0;
    logic [11:0] pwr_limit = '0;
    logic [15:0] budget_max = '0;
    logic [3:0]  core_active = '0;
    logic [3:0]  pstate_out;
    logic [3:0]  gated_out;
    logic [15:0] budget_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb[$];
    int m_p = P1;
    int m_b = 0;
    logic [3:0] m_g = '0;

    always #4 clk = ~clk;

    turbo_governor uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .os_req(os_req),
        .pwr_meas(pwr_meas), .pwr_limit(pwr_limit), .budget_max(budget_max),
        .core_active(core_active), .pstate_out(pstate_out),
        .gated_out(gated_out), .budget_out(budget_out)
    );

    // R5 top-bin table for four cores and P1 = 4
    function automatic int cap_of(input logic [3:0] a);
        case ($countones(a))
            0, 1:    return 0;
            2:       return 1;
            3:       return 2;
            default: return 3;
        endcase
    endfunction

    // driver: apply one cycle of inputs, advance the model, queue the expectation
    task automatic step(input bit tk, input int req, input int pwr, input int lim,
                        input int mx, input logic [3:0] act, input string tag);
        int tgt;
        int s;
        @(negedge clk);
        tick = tk; os_req = 4'(req); pwr_meas = 12'(pwr); pwr_limit = 12'(lim);
        budget_max = 16'(mx); core_active = act;
        if (tk) begin
            if (req == 0) tgt = (m_b == 0 && pwr > lim) ? P1 : cap_of(act);
            else if (req < P1) tgt = P1;
            else if (req > PN) tgt = PN;
            else tgt = req;
            if (m_p < tgt) m_p++;
            else if (m_p > tgt) m_p--;
            s = m_b + lim - pwr;
            m_b = (s < 0) ? 0 : (s > mx) ? mx : s;
            m_g = ~act;
        end
        @(posedge clk);
        #1;
        sb.push_back('{m_p, m_b, m_g, tag});
    endtask

    // monitor: compare each queued expectation on the following falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (int'(pstate_out) != e.p || int'(budget_out) != e.b || gated_out != e.g) begin
                    bad++;
                    $display("FAIL %s: got p=%0d b=%0d g=%b, expected p=%0d b=%0d g=%b",
                             e.tag, pstate_out, budget_out, gated_out, e.p, e.b, e.g);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 1000, 4'b0000, "R1 reset state");
        for (int i = 0; i < 3; i++) step(0, 0, 900, 100, 1000, 4'b0001, "R6 no tick holds");
        // climb with one active core: budget grows by 50 per tick, R2 R5 R7
        for (int i = 0; i < 5; i++) step(1, 0, 50, 100, 1000, 4'b0001, "R7 climb to bin 0");
        // four active cores: top bin drops to 3, one step per tick, R5 R6
        for (int i = 0; i < 4; i++) step(1, 0, 100, 100, 1000, 4'b1111, "R5 four-core cap");
        // same tick: budget drains to zero while decision still uses old budget, R10
        step(1, 0, 900, 100, 1000, 4'b1111, "R10 drain tick holds bin");
        step(1, 0, 900, 100, 1000, 4'b1111, "R8 retreat to P1");
        step(1, 0, 900, 100, 1000, 4'b1111, "R8 stays at P1");
        step(1, 0, 900, 100, 1000, 4'b1111, "R2 floor at zero");
        // ceiling, R3
        step(1, 0, 0, 600, 1000, 4'b1111, "R3 fill");
        step(1, 0, 0, 600, 1000, 4'b1111, "R3 saturate at max");
        step(1, 0, 0, 600, 300, 4'b1111, "R3 lowered max clips");
        // OS requests, R9
        for (int i = 0; i < 3; i++) step(1, 7, 100, 100, 300, 4'b1111, "R9 request 7");
        for (int i = 0; i < 4; i++) step(1, 2, 100, 100, 300, 4'b1111, "R9 request 2 maps to P1");
        for (int i = 0; i < 7; i++) step(1, 15, 100, 100, 300, 4'b1111, "R9 request 15 clamps to PN");
        // gating, R4
        step(1, 15, 100, 100, 300, 4'b0110, "R4 gated mask");
        step(0, 15, 100, 100, 300, 4'b1111, "R4 mask held without tick");
        // turbo from slowest point with two cores, R5 R7
        for (int i = 0; i < 10; i++) step(1, 0, 80, 100, 300, 4'b0110, "R7 two-core descent");
        step(1, 0, 80, 100, 300, 4'b0000, "R4 all cores gated");
        step(0, 0, 0, 0, 300, 4'b0000, "R6 final hold");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule